// File: doc/BRIEF.md
# Management Serial Bus Master

This block is the bit-level master for a two-wire management bus: a clock output and one shared data line that either end can drive. A host hands over one request at a time: a frame format, a read/write flag, a PHY address, an 8-bit register number and write data. The master then sends the whole 64-bit frame and hands back read data at the end. The master drives the bus clock from a run-time half-period count. It owns the output-enable of the data pad.

Three frame formats are supported. The standard format carries a 5-bit PHY address, a 5-bit register address and 16 data bits. Two extended formats carry an 8-bit register number: the low five bits go in the register field and the top three bits go in the PHY-address field. The two extended formats differ in where the read/write indication sits. Format A puts it in the first PHY-field bit and sends opcode 00. Format B puts it in the opcode and fixes the two middle PHY-field bits at 1. In both extended formats only the low byte of the data phase is meaningful.

Top module: `mgmt_serial_master`

## Requirements
- R1: Every frame opens with 32 bus clocks of the line driven high, followed by the start bits 0 then 1, sent most significant field bit first throughout.
- R2: `req_mode` 2'b00 (and 2'b11, treated alike) selects the standard format. The opcode is 1,0 for a read and 0,1 for a write. It is followed by `req_phy[4:0]`, `req_reg[4:0]` and all 16 bits of `req_wdata`.
- R3: `req_mode` 2'b01 selects format A. The opcode is 0,0. The PHY field, first bit to last, is: 1 for read or 0 for write, then a driven 0, then `req_reg[7:5]`. The register field is `req_reg[4:0]`.
- R4: `req_mode` 2'b10 selects format B. The opcode is 1,0 for a read and 0,1 for a write. The PHY field, first to last, is `req_reg[7]`, `req_reg[6]`, 1, 1, `req_reg[5]`. The register field is `req_reg[4:0]`.
- R5: On a write, the two turnaround bits are driven as 1 then 0, and data follows MSB first. In formats A and B the upper 8 data bits are driven as 0, followed by `req_wdata[7:0]`.
- R6: On a read, the output enable drops from the first turnaround bit (frame bit 46) to the end of the frame. `rdata` holds the 16 data bits sampled MSB first. `ta_err` is 1 when the second turnaround bit is sampled as 1.
- R7: `mdc` spends `div_i` clock cycles in each half period (0 acts as 1). `mdio_o` and `mdio_oe` change only while `mdc` is low and never on a rising edge, where read data is sampled.
- R8: `req_ready` is high when idle, and a request is taken on `req_valid && req_ready`. `req_ready` stays low during a frame. `done` pulses for one cycle after the last falling edge, with `req_ready` high in the same cycle. `rdata` and `ta_err` hold until the next request.
- R9: Out of reset and after every frame, `mdio_oe` is 0 and `mdc` rests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_i | input | DIV_W | Clock cycles per management-clock half period |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request accepted this cycle if valid |
| req_mode | input | 2 | Frame format: 00/11 standard, 01 format A, 10 format B |
| req_rd | input | 1 | 1 read, 0 write |
| req_phy | input | 5 | PHY address (standard format only) |
| req_reg | input | 8 | Register number |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | 16 | Read data of the last frame |
| ta_err | output | 1 | Target failed to pull the second turnaround bit low |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
A target model on the bench returns a chosen response word and a chosen turnaround bit. Each format is run as both a read and a write, with register numbers whose top three bits differ. This shows whether those bits landed in the right PHY-field positions for format A or format B, and whether the direction went to the opcode or to the PHY field. Write data with a non-zero high byte separates the standard format, which sends all 16 bits, from the extended ones, which must zero that byte. The spare mode code and a half-period of zero are also run. A read with a bad turnaround bit must raise `ta_err` and must not disturb the data capture.

// File: rtl/mgmt_pkg.sv
// Shared types and frame geometry of the management serial master.
// Assumes a fixed 64-bit frame: 32 preamble bits plus a 32-bit tail.
package mgmt_pkg;

    typedef enum logic [1:0] {
        FMT_STD   = 2'b00,
        FMT_PHYRW = 2'b01,
        FMT_OPRW  = 2'b10,
        FMT_SPARE = 2'b11
    } fmt_e;

    localparam int IDX_W     = 6;
    localparam int TAIL_BITS = 32;
    localparam logic [IDX_W-1:0] TA1_IDX  = 6'd46;
    localparam logic [IDX_W-1:0] TA2_IDX  = 6'd47;
    localparam logic [IDX_W-1:0] DATA_IDX = 6'd48;
    localparam logic [IDX_W-1:0] LAST_IDX = 6'd63;

endpackage

// File: rtl/mgmt_half_timer.sv
// Half-period timer: pulses tick once every div_i cycles while run is high.
// Assumes div_i holds steady during a frame; a value of 0 behaves as 1.
module mgmt_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // Effective count limit, zero promoted to one.
    always_comb lim = (div_i == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div_i;

    assign tick = run && (cnt == lim - 1'b1);

    // Cycle counter, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mgmt_frame_enc.sv
// Frame encoder: builds the 32 bits that follow the preamble
// (start, opcode, PHY field, register field, turnaround, data).
// Purely combinational; read frames carry zero turnaround and data.
module mgmt_frame_enc
    import mgmt_pkg::*;
(
    input  fmt_e                  fmt,
    input  logic                  rd,
    input  logic [4:0]            phy,
    input  logic [7:0]            regn,
    input  logic [15:0]           wdata,
    output logic [TAIL_BITS-1:0]  tail
);
    logic [1:0]  op;
    logic [4:0]  phy_f;
    logic [1:0]  ta;
    logic [15:0] dat;

    // Field selection for the three encodings.
    always_comb begin
        op    = rd ? 2'b10 : 2'b01;
        phy_f = phy;
        dat   = wdata;
        case (fmt)
            FMT_PHYRW: begin
                op    = 2'b00;
                phy_f = {rd, 1'b0, regn[7:5]};
                dat   = {8'h00, wdata[7:0]};
            end
            FMT_OPRW: begin
                phy_f = {regn[7:6], 2'b11, regn[5]};
                dat   = {8'h00, wdata[7:0]};
            end
            default: ;
        endcase
        ta = rd ? 2'b00 : 2'b10;
        if (rd)
            dat = 16'h0000;
        tail = {2'b01, op, phy_f, regn[4:0], ta, dat};
    end
endmodule

// File: rtl/mgmt_serial_master.sv
// Management serial bus master top. Accepts one request at a time, shifts a
// 64-bit frame on the data line, changing data while mdc is low and sampling
// read data on each rising edge. Assumes an external pull-up on the data line.
module mgmt_serial_master
    import mgmt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_mode,
    input  logic             req_rd,
    input  logic [4:0]       req_phy,
    input  logic [7:0]       req_reg,
    input  logic [15:0]      req_wdata,
    output logic             done,
    output logic [15:0]      rdata,
    output logic             ta_err,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic                 busy;
    logic                 rd_r;
    logic [IDX_W-1:0]     idx;
    logic                 mdc_r;
    logic [TAIL_BITS-1:0] tail_r;
    logic [TAIL_BITS-1:0] tail_nx;
    logic [15:0]          rdata_r;
    logic                 ta_err_r;
    logic                 done_r;
    logic                 tick;
    logic                 bit_val;

    mgmt_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div_i (div_i),
        .tick  (tick)
    );

    mgmt_frame_enc u_enc (
        .fmt   (fmt_e'(req_mode)),
        .rd    (req_rd),
        .phy   (req_phy),
        .regn  (req_reg),
        .wdata (req_wdata),
        .tail  (tail_nx)
    );

    // Current bit: preamble ones for the first half, then the tail MSB first.
    always_comb bit_val = idx[5] ? tail_r[~idx[4:0]] : 1'b1;

    assign req_ready = !busy;
    assign mdc       = mdc_r;
    assign mdio_oe   = busy && !(rd_r && (idx >= TA1_IDX));
    assign mdio_o    = busy ? bit_val : 1'b1;
    assign done      = done_r;
    assign rdata     = rdata_r;
    assign ta_err    = ta_err_r;

    // Frame sequencer: accept, toggle clock on ticks, shift and sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            rd_r     <= 1'b0;
            idx      <= '0;
            mdc_r    <= 1'b0;
            tail_r   <= '0;
            rdata_r  <= '0;
            ta_err_r <= 1'b0;
            done_r   <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (!busy) begin
                if (req_valid) begin
                    busy     <= 1'b1;
                    rd_r     <= req_rd;
                    idx      <= '0;
                    mdc_r    <= 1'b0;
                    tail_r   <= tail_nx;
                    rdata_r  <= '0;
                    ta_err_r <= 1'b0;
                end
            end else if (tick) begin
                if (!mdc_r) begin
                    mdc_r <= 1'b1;
                    if (rd_r && (idx == TA2_IDX))
                        ta_err_r <= mdio_i;
                    if (rd_r && (idx >= DATA_IDX))
                        rdata_r <= {rdata_r[14:0], mdio_i};
                end else begin
                    mdc_r <= 1'b0;
                    if (idx == LAST_IDX) begin
                        busy   <= 1'b0;
                        done_r <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mgmt_serial_checker.sv
// Protocol checker for mgmt_serial_master, bound into every instance.
// Observes ports plus the sequencer's busy, direction and bit index.
module mgmt_serial_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic       busy,
    input logic       rd_r,
    input logic [5:0] idx
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mdio_oe && !mdc)); // R9
    AST_RISE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R7
    AST_READ_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_r && idx > 6'd46) |-> !mdio_oe); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R8
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
endmodule

bind mgmt_serial_master mgmt_serial_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (busy),
    .rd_r      (rd_r),
    .idx       (idx)
);

// File: tb/sim_mgmt_serial_master.sv
// Bench: vector table of frames across all formats, then directed cases.
module sim_mgmt_serial_master;
    localparam int CLK_P = 10;
    localparam int DIV_W = 8;

    typedef struct packed {
        logic [1:0]  mode;
        logic        rd;
        logic [4:0]  phy;
        logic [7:0]  regn;
        logic [15:0] wdata;
        logic [15:0] resp;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 1'b0, 5'h05, 8'h1B, 16'hA5C3, 16'h0000},
        '{2'b00, 1'b1, 5'h12, 8'h09, 16'h0000, 16'h8E71},
        '{2'b01, 1'b0, 5'h00, 8'hB6, 16'h3C5A, 16'h0000},
        '{2'b01, 1'b1, 5'h00, 8'h4D, 16'h0000, 16'h00E7},
        '{2'b10, 1'b0, 5'h00, 8'hD4, 16'hFF96, 16'h0000},
        '{2'b10, 1'b1, 5'h00, 8'h2F, 16'h0000, 16'h0081},
        '{2'b11, 1'b0, 5'h1F, 8'hE0, 16'h0001, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIV_W-1:0] div_i = 8'd2;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_mode = '0;
    logic req_rd = 1'b0;
    logic [4:0] req_phy = '0;
    logic [7:0] req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic done, ta_err, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int rise_n = 0;
    logic [15:0] rsp_word = '0;
    logic ta_bad = 1'b0;
    logic [63:0] cap_o, cap_oe;
    time t0, t1;
    logic mid_ready;
    logic got_done;

    always #(CLK_P/2) clk = ~clk;

    mgmt_serial_master #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .div_i(div_i),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_rd(req_rd), .req_phy(req_phy),
        .req_reg(req_reg), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .ta_err(ta_err),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Target model: present the next bit while the clock is low.
    always @(negedge mdc) begin
        if (rise_n == 47)
            mdio_i = ta_bad;
        else if (rise_n >= 48 && rise_n <= 63)
            mdio_i = rsp_word[63 - rise_n];
        else
            mdio_i = 1'b1;
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog expired act=hung exp=finished");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Expected 32-bit tail, built from the requirement text.
    function automatic logic [31:0] exp_tail(input logic [1:0] m, input logic rd,
            input logic [4:0] ph, input logic [7:0] rg, input logic [15:0] wd);
        logic [1:0] op;
        logic [4:0] pf;
        logic [15:0] d;
        case (m)
            2'b01: begin op = 2'b00; pf = {rd, 1'b0, rg[7:5]}; d = {8'h00, wd[7:0]}; end
            2'b10: begin op = rd ? 2'b10 : 2'b01; pf = {rg[7], rg[6], 1'b1, 1'b1, rg[5]}; d = {8'h00, wd[7:0]}; end
            default: begin op = rd ? 2'b10 : 2'b01; pf = ph; d = wd; end
        endcase
        return {2'b01, op, pf, rg[4:0], (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : d)};
    endfunction

    task automatic run_frame(input logic [1:0] m, input logic rd, input logic [4:0] ph,
            input logic [7:0] rg, input logic [15:0] wd, input logic [15:0] resp,
            input logic tabad);
        rsp_word = resp;
        ta_bad   = tabad;
        rise_n   = 0;
        @(negedge clk);
        req_mode = m; req_rd = rd; req_phy = ph; req_reg = rg; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 64; k++) begin
            @(posedge mdc);
            cap_o[63-k]  = mdio_o;
            cap_oe[63-k] = mdio_oe;
            if (k == 0) t0 = $time;
            if (k == 1) t1 = $time;
            if (k == 10) mid_ready = req_ready;
            rise_n = k + 1;
        end
        got_done = 1'b0;
        for (int w = 0; w < 600; w++) begin
            @(negedge clk);
            if (done) begin
                got_done = 1'b1;
                break;
            end
        end
    endtask

    // Run one frame and check everything it shows.
    task automatic check_frame(input logic [1:0] m, input logic rd, input logic [4:0] ph,
            input logic [7:0] rg, input logic [15:0] wd, input logic [15:0] resp,
            input logic tabad);
        logic [63:0] ef, eo;
        run_frame(m, rd, ph, rg, wd, resp, tabad);
        ef = {32'hFFFF_FFFF, exp_tail(m, rd, ph, rg, wd)};
        eo = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        chk("R8 done pulse", {63'h0, got_done}, 64'h1);
        // R1/R2/R3/R4/R5: driven bits of the frame
        if (rd)
            chk("R1/R2/R3/R4 read header", {18'h0, cap_o[63:18]}, {18'h0, ef[63:18]});
        else
            chk("R1/R2/R3/R4/R5 write frame", cap_o, ef);
        chk("R6 output enable", cap_oe, eo);
        if (rd) begin
            chk("R6 read data", {48'h0, rdata}, {48'h0, resp});
            chk("R6 turnaround flag", {63'h0, ta_err}, {63'h0, tabad});
        end
    endtask

    initial begin
        // Reset state (R9, R8)
        repeat (3) @(negedge clk);
        chk("R8 ready in reset", {63'h0, req_ready}, 64'h1);
        chk("R9 oe in reset", {63'h0, mdio_oe}, 64'h0);
        chk("R9 mdc in reset", {63'h0, mdc}, 64'h0);
        chk("R8 done in reset", {63'h0, done}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk across formats and directions.
        for (int v = 0; v < NVEC; v++) begin
            check_frame(VECS[v].mode, VECS[v].rd, VECS[v].phy, VECS[v].regn,
                        VECS[v].wdata, VECS[v].resp, 1'b0);
            chk("R7 bit period div2", 64'(t1 - t0), 64'(4 * CLK_P));
        end
        chk("R8 ready low mid-frame", {63'h0, mid_ready}, 64'h0);

        // R9: released and clock low after a frame
        @(negedge clk);
        chk("R9 oe after frame", {63'h0, mdio_oe}, 64'h0);
        chk("R9 mdc after frame", {63'h0, mdc}, 64'h0);

        // R6: target fails to pull second turnaround bit low
        check_frame(2'b01, 1'b1, 5'h0, 8'hE3, 16'h0, 16'h005A, 1'b1);
        // R6: flag cleared by the next good read
        check_frame(2'b10, 1'b1, 5'h0, 8'h61, 16'h0, 16'h00C4, 1'b0);

        // R7: half period of three cycles
        div_i = 8'd3;
        check_frame(2'b00, 1'b0, 5'h0A, 8'h15, 16'h5AA5, 16'h0, 1'b0);
        chk("R7 bit period div3", 64'(t1 - t0), 64'(6 * CLK_P));
        // R7: zero acts as one
        div_i = 8'd0;
        check_frame(2'b00, 1'b1, 5'h01, 8'h1F, 16'h0, 16'hFFFF, 1'b0);
        chk("R7 bit period div0", 64'(t1 - t0), 64'(2 * CLK_P));

        summary();
        $finish;
    end
endmodule